// File: doc/BRIEF.md
# Burst-of-Two Pipelined SRAM Core

This block is a synthesizable behavioural model of a synchronous SRAM that moves data in bursts of two words over a shared data port. The model runs on one beat-rate clock. Commands are taken only on even beats. A command is either a read, a write or an idle (NOP) slot. It is given by a load strobe, a read/write select and a word address. The first word of a burst belongs to the given address. The second belongs to the same address with bit 0 inverted, so the burst wraps inside an aligned pair of words.

Write data arrives on the two beats after the write command. The completed burst is held in a pending-write register. The register is written into the array only when the next write's data is complete, which makes the array a late-write array. A read whose word pair matches the pending write returns the pending data for both beats. A read returns its two words four beats after it is captured, which is two command cycles. During those two beats a valid flag is raised and the output enable drives the shared bus. A surrounding system chains reads back to back. It leaves at least one idle command between a read and a following write, so that the write data does not collide with the read data on the bus.

Top module: `burst_sram_core`

## Requirements
- R1: A command is captured only at an even beat, where the first clock edge after reset release is even. A strobe raised at an odd beat has no effect on the array or on the outputs.
- R2: For a read captured at even edge t, data_vld_o is high after edge t+4 and after edge t+5. Otherwise it is low unless another read is in flight.
- R3: Beat 0 of a read carries the word at the command address A. Beat 1 carries the word at A with bit 0 inverted.
- R4: For a write captured at edge t, dq_i is sampled at edge t+2 as the word for A. It is sampled at edge t+3 as the word for A with bit 0 inverted.
- R5: A read returns the newest written data for both words. This holds even while that data is still in the pending-write register and not yet in the array.
- R6: dq_oe_o is high exactly on read-data beats. One beat after the last beat of a read that is followed by an idle command, it is low.
- R7: Reads captured on consecutive command slots produce an unbroken stream of valid beats, in command order.
- R8: While rst_ni is low, data_vld_o and dq_oe_o are low. A completed write still pending at reset is discarded, and the array keeps its earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beat-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_ld_i | input | 1 | Command strobe, high for read or write, low for NOP |
| cmd_rd_i | input | 1 | 1 = read, 0 = write |
| cmd_addr_i | input | AW | Word address of burst beat 0 |
| dq_i | input | DW | Write data beats |
| dq_o | output | DW | Read data beats |
| dq_oe_o | output | 1 | Drive enable for the shared data bus |
| data_vld_o | output | 1 | High on beats carrying read data |

## Verification
The whole array is first written with address-derived data, so any read has a known answer. The random stream then mixes reads, writes and NOPs at a fixed seed. Random strobes are raised on odd beats, so an odd-beat capture would show up as stray valid beats or corrupted words. Directed cases separate three sources of read data. A read of a pair still pending returns forwarded data. A read of an odd base address checks the wrapped word order. A read after reset of a pair whose write was pending returns the older array contents. Runs of back-to-back reads separate a streaming pipeline from one that inserts gaps.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;

  localparam int unsigned BEATS = 2;
endpackage

// File: rtl/bsr_cmd_pipe.sv
module bsr_cmd_pipe
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  output logic          even_o,
  output op_e           s1_op_o,
  output op_e           s2_op_o,
  output logic [AW-1:0] s2_addr_o
);
  logic          odd_q;
  op_e           s1_op_q, s2_op_q;
  logic [AW-1:0] s1_addr_q, s2_addr_q;
  op_e           new_op;

  always_comb begin
    if (!ld_i)     new_op = OP_NOP;
    else if (rd_i) new_op = OP_RD;
    else           new_op = OP_WR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q     <= 1'b0;
      s1_op_q   <= OP_NOP;
      s2_op_q   <= OP_NOP;
      s1_addr_q <= '0;
      s2_addr_q <= '0;
    end else begin
      odd_q <= ~odd_q;
      if (!odd_q) begin
        s1_op_q   <= new_op;
        s1_addr_q <= addr_i;
        s2_op_q   <= s1_op_q;
        s2_addr_q <= s1_addr_q;
      end
    end
  end

  assign even_o    = ~odd_q;
  assign s1_op_o   = s1_op_q;
  assign s2_op_o   = s2_op_q;
  assign s2_addr_o = s2_addr_q;
endmodule

// File: rtl/bsr_wr_buf.sv
module bsr_wr_buf
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16,
  localparam int unsigned RW = AW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          even_i,
  input  op_e           s1_op_i,
  input  op_e           s2_op_i,
  input  logic [AW-1:0] s2_addr_i,
  input  logic [DW-1:0] dq_i,
  output logic          pend_v_o,
  output logic [RW-1:0] pend_row_o,
  output logic [DW-1:0] pend_lo_o,
  output logic [DW-1:0] pend_hi_o,
  output logic          commit_o
);
  logic [DW-1:0] beat0_q;
  logic          pend_v_q;
  logic [AW-1:0] pend_addr_q;
  logic [DW-1:0] pend_d0_q, pend_d1_q;
  logic          cap0, cap1;

  assign cap0 = even_i && (s1_op_i == OP_WR);
  assign cap1 = !even_i && (s2_op_i == OP_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat0_q     <= '0;
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      pend_d0_q   <= '0;
      pend_d1_q   <= '0;
    end else begin
      if (cap0) beat0_q <= dq_i;
      if (cap1) begin
        pend_v_q    <= 1'b1;
        pend_addr_q <= s2_addr_i;
        pend_d0_q   <= beat0_q;
        pend_d1_q   <= dq_i;
      end
    end
  end

  // previous burst leaves for the array when the next one completes
  assign commit_o   = cap1 && pend_v_q;
  assign pend_v_o   = pend_v_q;
  assign pend_row_o = pend_addr_q[AW-1:1];
  assign pend_lo_o  = pend_addr_q[0] ? pend_d1_q : pend_d0_q;
  assign pend_hi_o  = pend_addr_q[0] ? pend_d0_q : pend_d1_q;
endmodule

// File: rtl/bsr_rd_path.sv
module bsr_rd_path
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16,
  localparam int unsigned RW   = AW - 1,
  localparam int unsigned ROWS = 1 << RW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          even_i,
  input  op_e           s2_op_i,
  input  logic [AW-1:0] s2_addr_i,
  input  logic          pend_v_i,
  input  logic [RW-1:0] pend_row_i,
  input  logic [DW-1:0] pend_lo_i,
  input  logic [DW-1:0] pend_hi_i,
  input  logic          commit_i,
  output logic [DW-1:0] dq_o,
  output logic          vld_o
);
  logic [2*DW-1:0] mem_q [ROWS];
  logic [DW-1:0]   word [BEATS];
  logic [DW-1:0]   buf_q [BEATS];
  logic [2*DW-1:0] pair;
  logic [RW-1:0]   row;
  logic            fetch, fire_q, second_q, vld_q;
  logic [DW-1:0]   dq_q;

  assign row   = s2_addr_i[AW-1:1];
  assign fetch = !even_i && (s2_op_i == OP_RD);
  assign pair  = (pend_v_i && pend_row_i == row) ? {pend_hi_i, pend_lo_i} : mem_q[row];

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    logic sel_hi;
    assign sel_hi  = s2_addr_i[0] ^ (b != 0);
    assign word[b] = sel_hi ? pair[2*DW-1:DW] : pair[DW-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (commit_i) mem_q[pend_row_i] <= {pend_hi_i, pend_lo_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q[0] <= '0;
      buf_q[1] <= '0;
      fire_q   <= 1'b0;
      second_q <= 1'b0;
      vld_q    <= 1'b0;
      dq_q     <= '0;
    end else if (even_i) begin
      second_q <= fire_q;
      vld_q    <= fire_q;
      fire_q   <= 1'b0;
      if (fire_q) dq_q <= buf_q[0];
    end else begin
      second_q <= 1'b0;
      vld_q    <= second_q;
      if (second_q) dq_q <= buf_q[1];
      fire_q <= fetch;
      if (fetch) begin
        buf_q[0] <= word[0];
        buf_q[1] <= word[1];
      end
    end
  end

  assign dq_o  = dq_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_ld_i,
  input  logic          cmd_rd_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          data_vld_o
);
  localparam int unsigned RW = AW - 1;

  logic          even;
  op_e           s1_op, s2_op;
  logic [AW-1:0] s2_addr;
  logic          pend_v, commit;
  logic [RW-1:0] pend_row;
  logic [DW-1:0] pend_lo, pend_hi;
  logic          vld;

  bsr_cmd_pipe #(.AW(AW)) u_cmd (
    .clk_i, .rst_ni,
    .ld_i(cmd_ld_i), .rd_i(cmd_rd_i), .addr_i(cmd_addr_i),
    .even_o(even), .s1_op_o(s1_op), .s2_op_o(s2_op), .s2_addr_o(s2_addr)
  );

  bsr_wr_buf #(.AW(AW), .DW(DW)) u_wr (
    .clk_i, .rst_ni,
    .even_i(even), .s1_op_i(s1_op), .s2_op_i(s2_op), .s2_addr_i(s2_addr),
    .dq_i,
    .pend_v_o(pend_v), .pend_row_o(pend_row),
    .pend_lo_o(pend_lo), .pend_hi_o(pend_hi), .commit_o(commit)
  );

  bsr_rd_path #(.AW(AW), .DW(DW)) u_rd (
    .clk_i, .rst_ni,
    .even_i(even), .s2_op_i(s2_op), .s2_addr_i(s2_addr),
    .pend_v_i(pend_v), .pend_row_i(pend_row),
    .pend_lo_i(pend_lo), .pend_hi_i(pend_hi), .commit_i(commit),
    .dq_o, .vld_o(vld)
  );

  assign data_vld_o = vld;
  assign dq_oe_o    = vld;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_ld_i,
  input logic cmd_rd_i,
  input logic dq_oe_o,
  input logic data_vld_o
);
  logic       odd_q;
  logic [2:0] age_q;
  logic       acc_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q <= 1'b0;
      age_q <= '0;
    end else begin
      odd_q <= ~odd_q;
      if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end
  end

  assign acc_rd = cmd_ld_i && cmd_rd_i && !odd_q;

  assert_rd_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rd |-> ##5 data_vld_o ##1 data_vld_o);

  assert_vld_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3'd7 && data_vld_o) |-> ($past(acc_rd, 5) || $past(acc_rd, 6)));

  assert_oe_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3'd7 && !$past(acc_rd, 5) && !$past(acc_rd, 6)) |-> !dq_oe_o);

  assert_odd_ignored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3'd7 && !$past(acc_rd, 5) && !$past(acc_rd, 6)) |-> !data_vld_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R8: assert (!dq_oe_o && !data_vld_o);
    end
  end
endmodule

bind burst_sram_core burst_sram_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_ld_i(cmd_ld_i), .cmd_rd_i(cmd_rd_i),
  .dq_oe_o(dq_oe_o), .data_vld_o(data_vld_o)
);

// File: tb/tb_burst_sram_core.sv
module tb_burst_sram_core;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b1;
  logic          cmd_ld_i = 1'b0, cmd_rd_i = 1'b0;
  logic [AW-1:0] cmd_addr_i = '0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o, data_vld_o;

  burst_sram_core #(.AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni, .cmd_ld_i, .cmd_rd_i, .cmd_addr_i,
    .dq_i, .dq_o, .dq_oe_o, .data_vld_o
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [DW-1:0] mem_m [WORDS];
  logic          pend_v_m;
  logic [AW-1:0] pend_a_m;
  logic [DW-1:0] pend_d0_m, pend_d1_m;
  logic          nxt_v;
  logic [AW-1:0] nxt_a;
  logic [DW-1:0] nxt_d0, nxt_d1;
  logic          cur_v;
  logic [DW-1:0] cur_d0, cur_d1;
  logic          ev [8];
  logic          efw [8];
  logic [DW-1:0] ew0 [8], ew1 [8];
  int            slot = 0;
  logic          last_rd = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] model_word(input logic [AW-1:0] a);
    if (pend_v_m && a[AW-1:1] == pend_a_m[AW-1:1])
      return (a == pend_a_m) ? pend_d0_m : pend_d1_m;
    return mem_m[a];
  endfunction

  task automatic check_beat(input int idx, input bit second);
    logic [DW-1:0] e;
    e = second ? ew1[idx] : ew0[idx];
    check(data_vld_o == ev[idx], "R2 vld", {15'd0, data_vld_o}, {15'd0, ev[idx]});
    check(dq_oe_o == ev[idx], "R6 oe", {15'd0, dq_oe_o}, {15'd0, ev[idx]});
    if (ev[idx]) begin
      if (efw[idx]) check(dq_o == e, second ? "R5 fwd beat1" : "R5 fwd beat0", dq_o, e);
      else          check(dq_o == e, second ? "R3 beat1" : "R3 beat0", dq_o, e);
    end
  endtask

  // one command slot = even beat + odd beat
  task automatic do_slot(input bit ld, input bit rd, input logic [AW-1:0] a, input bit junk);
    logic [AW-1:0] b;
    @(negedge clk);
    check_beat((slot + 5) % 8, 1'b1);
    cur_v = nxt_v; cur_d0 = nxt_d0; cur_d1 = nxt_d1;
    if (nxt_v) begin // R4: data of previous write completes in this slot
      if (pend_v_m) begin
        mem_m[pend_a_m] = pend_d0_m;
        mem_m[pend_a_m ^ 1] = pend_d1_m;
      end
      pend_v_m = 1'b1; pend_a_m = nxt_a; pend_d0_m = nxt_d0; pend_d1_m = nxt_d1;
    end
    nxt_v = 1'b0;
    cmd_ld_i = ld; cmd_rd_i = rd; cmd_addr_i = a;
    dq_i = cur_v ? cur_d0 : DW'($urandom);
    b = a ^ AW'(1);
    ev[slot % 8]  = ld && rd;
    efw[slot % 8] = pend_v_m && a[AW-1:1] == pend_a_m[AW-1:1];
    ew0[slot % 8] = model_word(a);
    ew1[slot % 8] = model_word(b);
    if (ld && !rd) begin
      nxt_v = 1'b1; nxt_a = a; nxt_d0 = DW'($urandom); nxt_d1 = DW'($urandom);
    end
    @(posedge clk);
    @(negedge clk);
    check_beat((slot + 6) % 8, 1'b0);
    cmd_ld_i = junk; cmd_rd_i = 1'($urandom); cmd_addr_i = AW'($urandom); // R1 odd strobe
    dq_i = cur_v ? cur_d1 : DW'($urandom);
    @(posedge clk);
    slot++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; cmd_ld_i = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(!dq_oe_o, "R8 oe in reset", {15'd0, dq_oe_o}, '0);
    check(!data_vld_o, "R8 vld in reset", {15'd0, data_vld_o}, '0);
    pend_v_m = 1'b0; nxt_v = 1'b0;
    for (int i = 0; i < 8; i++) ev[i] = 1'b0;
    slot = 0;
    rst_ni = 1'b1;
    @(posedge clk); @(posedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    pend_v_m = 1'b0; nxt_v = 1'b0;
    for (int i = 0; i < 8; i++) begin ev[i] = 1'b0; efw[i] = 1'b0; end
    #1 rst_ni = 1'b0;
    do_reset();
    // fill every pair, then rewrite pair 0 so pair 31 commits
    for (int r = 0; r < WORDS / 2; r++) do_slot(1'b1, 1'b0, AW'(2 * r), 1'b0);
    do_slot(1'b1, 1'b0, AW'(0), 1'b0);
    do_slot(1'b0, 1'b0, '0, 1'b0);
    // R8: pending pair 0 dropped by reset, array keeps the fill value
    do_reset();
    do_slot(1'b1, 1'b1, AW'(0), 1'b0);
    do_slot(1'b1, 1'b1, AW'(1), 1'b0);
    do_slot(1'b0, 1'b0, '0, 1'b0);
    // R5: write then read same pair while pending; odd base for R3 wrap
    do_slot(1'b1, 1'b0, AW'(9), 1'b0);
    do_slot(1'b1, 1'b1, AW'(9), 1'b0);
    do_slot(1'b1, 1'b1, AW'(8), 1'b1);
    do_slot(1'b1, 1'b1, AW'(33), 1'b1);
    do_slot(1'b0, 1'b0, '0, 1'b0);
    // R6: release after idle, then R7 streaming run
    do_slot(1'b0, 1'b0, '0, 1'b1);
    for (int k = 0; k < 6; k++) do_slot(1'b1, 1'b1, AW'(5 * k + 3), 1'b1);
    do_slot(1'b0, 1'b0, '0, 1'b0);
    // R1: odd-beat write strobes must not alter anything
    for (int k = 0; k < 4; k++) do_slot(1'b0, 1'b0, '0, 1'b1);
    do_slot(1'b1, 1'b1, AW'(12), 1'b1);
    do_slot(1'b0, 1'b0, '0, 1'b0);
    // random mix
    last_rd = 1'b0;
    for (int k = 0; k < 400; k++) begin
      bit ld, rd;
      ld = ($urandom % 5) != 0;
      rd = 1'($urandom);
      if (ld && !rd && last_rd) ld = 1'b0;
      last_rd = ld && rd;
      do_slot(ld, rd, AW'($urandom), 1'($urandom));
    end
    for (int k = 0; k < 4; k++) do_slot(1'b0, 1'b0, '0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule